// File: doc/BRIEF.md
# Prescaled Overflow Wake Timer with BCD Time of Day

This block keeps the time of day for a system that sleeps most of the time. It runs on the system clock. A one-cycle enable, `xtal_tick`, marks each period of a 32.768 kHz crystal that has already been synchronised. A prescaler divides these ticks by two and feeds a 16-bit up counter. When the counter steps from all ones to zero, a one-cycle wake request is raised and a sticky overflow flag is set. The flag stays set until the servicing logic clears it. At nominal settings this happens every four seconds.

Each rollover is counted. On every fifteenth rollover the minutes field advances by one. When the minutes wrap, the hours field advances. Both fields are kept as two-digit BCD. A set-time strobe loads hours and minutes and restarts the whole timebase. A test-mode input reloads the counter with 16'hFF80 instead of zero after every rollover. This shortens one period to 128 counter steps (256 crystal ticks, about 7.8 ms), so that minute and hour carries can be exercised quickly.

Top module: `wake_timer`

## Requirements
- R1: While reset is asserted and directly after it, hours and minutes read 8'h00, and `ovf_flag` and `wake_req` are low.
- R2: The counter advances once for every two `xtal_tick` pulses; cycles without `xtal_tick` do not advance anything, so a tick on every second cycle doubles the period in clock cycles.
- R3: With test mode off, the first rollover after reset happens on the 131072nd `xtal_tick` (65536 counter steps of two ticks each).
- R4: `wake_req` is high for exactly one cycle per rollover, and `ovf_flag` becomes high in that same cycle.
- R5: `ovf_flag` stays high until `ovf_clear` is sampled high; when a rollover and `ovf_clear` meet in the same cycle, the flag ends up set.
- R6: Minutes advance by one on every fifteenth rollover and do not change on the fourteen rollovers before it.
- R7: Minutes count 00 to 59 in BCD (upper nibble tens, lower nibble units); leaving 59 gives 00 and advances the hours by one.
- R8: Hours count 00 to 23 in BCD (upper nibble tens, lower nibble units), a units carry from 9 gives the next ten, and 23 wraps to 00.
- R9: With `test_mode` high, each rollover reloads the counter with 16'hFF80, so successive wake requests are 256 `xtal_tick` pulses apart.
- R10: `set_en` loads `set_hours` and `set_minutes` and clears the prescaler and the rollover count. It loads the counter with 16'hFF80 when `test_mode` is high and with zero otherwise. It takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_tick | input | 1 | One-cycle pulse per crystal period, already synchronised |
| test_mode | input | 1 | Selects the short reload value after each rollover |
| set_en | input | 1 | Loads the time and restarts the timebase |
| set_hours | input | 8 | BCD hours to load, 00 to 23 |
| set_minutes | input | 8 | BCD minutes to load, 00 to 59 |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| wake_req | output | 1 | One-cycle wake pulse on each rollover |
| hours | output | 8 | Current hours in BCD |
| minutes | output | 8 | Current minutes in BCD |

## Verification
The assertions assume that every time loaded through `set_en` is valid BCD within range, because the range checks on `hours` and `minutes` hold only if no illegal value is ever loaded. They also assume that `xtal_tick` is a clean one-cycle enable, not a raw asynchronous level. The bench loads only legal times such as 12:34, 12:59, 09:59 and 23:59. It drives ticks either on every cycle or on every second cycle, always away from the active edge, and it uses test mode for every scenario except the one long check of the nominal period.

// File: rtl/wake_timer_pkg.sv
package wake_timer_pkg;

   typedef logic [7:0] bcd2_t;

   localparam bcd2_t MIN_LAST  = 8'h59;
   localparam bcd2_t HOUR_LAST = 8'h23;

   // returns {wrapped, next value} for a two-digit BCD count ending at last
   function automatic logic [8:0] bcd_step(input bcd2_t v, input bcd2_t last);
      logic [8:0] r;
      if (v == last)
         r = {1'b1, 8'h00};
      else if (v[3:0] == 4'd9)
         r = {1'b0, v[7:4] + 4'd1, 4'd0};
      else
         r = {1'b0, v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic en
);
   generate
      if (DIV == 1) begin : g_pass
         assign en = tick & ~clr;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pcnt <= '0;
            else if (clr)
               pcnt <= '0;
            else if (tick)
               pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
         end
         assign en = tick & ~clr & (pcnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/wt_rollover.sv
module wt_rollover #(
   parameter int              CNT_W  = 16,
   parameter logic [CNT_W-1:0] RELOAD = 16'hFF80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic load,
   input  logic test_mode,
   output logic roll
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] start_val;

   assign start_val = test_mode ? RELOAD : '0;
   assign roll      = en & ~load & (cnt == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load || roll)
         cnt <= start_val;
      else if (en)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/wt_clock_bcd.sv
module wt_clock_bcd
   import wake_timer_pkg::*;
#(
   parameter int TICKS_PER_MIN = 15
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  roll,
   input  logic  set_en,
   input  bcd2_t set_h,
   input  bcd2_t set_m,
   output bcd2_t hours,
   output bcd2_t minutes
);
   logic       min_adv;
   logic [8:0] m_nxt;
   logic [8:0] h_nxt;

   generate
      if (TICKS_PER_MIN == 1) begin : g_direct
         assign min_adv = roll & ~set_en;
      end else begin : g_count
         localparam int TW = $clog2(TICKS_PER_MIN);
         localparam logic [TW-1:0] TLAST = TW'(TICKS_PER_MIN - 1);
         logic [TW-1:0] tcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tcnt <= '0;
            else if (set_en)
               tcnt <= '0;
            else if (roll)
               tcnt <= (tcnt == TLAST) ? '0 : tcnt + 1'b1;
         end
         assign min_adv = roll & ~set_en & (tcnt == TLAST);
      end
   endgenerate

   assign m_nxt = bcd_step(minutes, MIN_LAST);
   assign h_nxt = bcd_step(hours, HOUR_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         minutes <= 8'h00;
         hours   <= 8'h00;
      end else if (set_en) begin
         minutes <= set_m;
         hours   <= set_h;
      end else if (min_adv) begin
         minutes <= m_nxt[7:0];
         if (m_nxt[8])
            hours <= h_nxt[7:0];
      end
   end
endmodule

// File: rtl/wake_timer.sv
module wake_timer
   import wake_timer_pkg::*;
#(
   parameter int              PRE_DIV       = 2,
   parameter int              CNT_W         = 16,
   parameter logic [CNT_W-1:0] TEST_RELOAD   = 16'hFF80,
   parameter int              TICKS_PER_MIN = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       xtal_tick,
   input  logic       test_mode,
   input  logic       set_en,
   input  logic [7:0] set_hours,
   input  logic [7:0] set_minutes,
   input  logic       ovf_clear,
   output logic       ovf_flag,
   output logic       wake_req,
   output logic [7:0] hours,
   output logic [7:0] minutes
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   generate
      if (PRE_DIV < 1) begin : g_bad_div
         $error("wake_timer: PRE_DIV must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_w
         $error("wake_timer: CNT_W must be at least 2");
      end
      if (TEST_RELOAD == ALL_ONES) begin : g_bad_reload
         $error("wake_timer: TEST_RELOAD must be below the counter maximum");
      end
      if (TICKS_PER_MIN < 1) begin : g_bad_ticks
         $error("wake_timer: TICKS_PER_MIN must be at least 1");
      end
   endgenerate

   logic step_en;
   logic roll;

   wt_prescaler #(.DIV(PRE_DIV)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (set_en),
      .tick  (xtal_tick),
      .en    (step_en)
   );

   wt_rollover #(.CNT_W(CNT_W), .RELOAD(TEST_RELOAD)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (step_en),
      .load      (set_en),
      .test_mode (test_mode),
      .roll      (roll)
   );

   wt_clock_bcd #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_time (
      .clk     (clk),
      .rst_n   (rst_n),
      .roll    (roll),
      .set_en  (set_en),
      .set_h   (set_hours),
      .set_m   (set_minutes),
      .hours   (hours),
      .minutes (minutes)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
         wake_req <= 1'b0;
      end else begin
         wake_req <= roll;
         if (roll)
            ovf_flag <= 1'b1;
         else if (ovf_clear)
            ovf_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/wake_timer_chk.sv
module wake_timer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       set_en,
   input logic       ovf_clear,
   input logic       ovf_flag,
   input logic       wake_req,
   input logic [7:0] hours,
   input logic [7:0] minutes
);
   // R4
   wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !wake_req);

   // R4
   wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> ovf_flag);

   // R5
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clear) |=> ovf_flag);

   // R5
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> wake_req);

   // R6
   min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake_req && !$past(set_en)) |-> $stable(minutes));

   // R7
   min_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (minutes[7:4] <= 4'd5) && (minutes[3:0] <= 4'd9));

   // R8
   hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hours <= 8'h23) && (hours[3:0] <= 4'd9));

   // R8
   hour_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake_req && !$past(set_en)) |-> $stable(hours));
endmodule

bind wake_timer wake_timer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .set_en    (set_en),
   .ovf_clear (ovf_clear),
   .ovf_flag  (ovf_flag),
   .wake_req  (wake_req),
   .hours     (hours),
   .minutes   (minutes)
);

// File: tb/tb_wake_timer.sv
module tb_wake_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xtal_tick = 1'b0;
   logic       test_mode = 1'b0;
   logic       set_en = 1'b0;
   logic [7:0] set_hours = 8'h00;
   logic [7:0] set_minutes = 8'h00;
   logic       ovf_clear = 1'b0;
   logic       ovf_flag;
   logic       wake_req;
   logic [7:0] hours;
   logic [7:0] minutes;

   int tests = 0;
   int fails = 0;
   int tick_mode = 0;   // 0 off, 1 every cycle, 2 every second cycle
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wake_timer dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .xtal_tick   (xtal_tick),
      .test_mode   (test_mode),
      .set_en      (set_en),
      .set_hours   (set_hours),
      .set_minutes (set_minutes),
      .ovf_clear   (ovf_clear),
      .ovf_flag    (ovf_flag),
      .wake_req    (wake_req),
      .hours       (hours),
      .minutes     (minutes)
   );

   always @(negedge clk) begin
      if (tick_mode == 1)      xtal_tick <= 1'b1;
      else if (tick_mode == 2) xtal_tick <= ~xtal_tick;
      else                     xtal_tick <= 1'b0;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 195000 && !done) begin
         done = 1'b1;
         tests = tests + 1;
         fails = fails + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests = tests + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_wake(output int n, input int limit);
      n = 0;
      forever begin
         @(posedge clk);
         n = n + 1;
         @(negedge clk);
         if (wake_req || n >= limit) break;
      end
   endtask

   task automatic load_time(input logic [7:0] h, input logic [7:0] m);
      @(negedge clk);
      set_hours = h;
      set_minutes = m;
      set_en = 1'b1;
      @(negedge clk);
      set_en = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      check("R1 hours in reset", hours, 8'h00);
      check("R1 minutes in reset", minutes, 8'h00);
      check("R1 flag in reset", ovf_flag, 1'b0);
      check("R1 wake in reset", wake_req, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      tick_mode = 1;
      @(negedge clk);
      check("R1 flag after reset", ovf_flag, 1'b0);
   endtask

   task automatic t_nominal;
      int n;
      wait_wake(n, 140000);
      // one cycle was already spent after reset release
      check("R3 R2 nominal period", n + 1, 131072);
      check("R4 flag with wake", ovf_flag, 1'b1);
      check("R6 minutes after one rollover", minutes, 8'h00);
      @(negedge clk);
      check("R4 wake one cycle", wake_req, 1'b0);
      check("R5 flag sticky", ovf_flag, 1'b1);
      ovf_clear = 1'b1;
      @(negedge clk);
      ovf_clear = 1'b0;
      check("R5 flag cleared", ovf_flag, 1'b0);
   endtask

   task automatic t_test_period;
      int n;
      test_mode = 1'b1;
      load_time(8'h12, 8'h34);
      check("R10 hours loaded", hours, 8'h12);
      check("R10 minutes loaded", minutes, 8'h34);
      wait_wake(n, 2000);
      check("R9 R10 first short period", n, 256);
      wait_wake(n, 2000);
      check("R9 reload period", n, 256);
      check("R6 minutes after two", minutes, 8'h34);
   endtask

   task automatic t_minute;
      int n;
      load_time(8'h12, 8'h34);
      for (int i = 0; i < 14; i++) wait_wake(n, 2000);
      check("R6 no advance at 14", minutes, 8'h34);
      wait_wake(n, 2000);
      check("R6 advance at 15", minutes, 8'h35);
      check("R6 hours kept", hours, 8'h12);
   endtask

   task automatic t_clear_collision;
      int n;
      ovf_clear = 1'b1;
      @(negedge clk);
      check("R5 flag low before", ovf_flag, 1'b0);
      wait_wake(n, 2000);
      check("R5 set wins over clear", ovf_flag, 1'b1);
      @(negedge clk);
      check("R5 clear next cycle", ovf_flag, 1'b0);
      ovf_clear = 1'b0;
   endtask

   task automatic t_wrap(input logic [7:0] h0, input logic [7:0] m0,
                         input logic [7:0] h1, input logic [7:0] m1, input string req);
      int n;
      load_time(h0, m0);
      for (int i = 0; i < 15; i++) wait_wake(n, 2000);
      check(req, {16'h0, hours, minutes}, {16'h0, h1, m1});
   endtask

   task automatic t_gap;
      int n;
      tick_mode = 2;
      load_time(8'h00, 8'h00);
      wait_wake(n, 4000);
      check("R2 gapped ticks period", (n >= 510 && n <= 512) ? 1 : 0, 1);
      tick_mode = 1;
   endtask

   initial begin
      t_reset;
      t_nominal;
      t_test_period;
      t_minute;
      t_clear_collision;
      t_wrap(8'h12, 8'h59, 8'h13, 8'h00, "R7 minute wrap");
      t_wrap(8'h09, 8'h59, 8'h10, 8'h00, "R8 hour units carry");
      t_wrap(8'h23, 8'h59, 8'h00, 8'h00, "R8 hour wrap");
      t_gap;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule